// File: doc/BRIEF.md
# Watermark Secure-Region Address Classifier

This block labels each access address as secure or non-secure. Two memory regions are known to it through parameters: an on-chip RAM region and a flash region, each with a base address and a size. A programmable watermark per region marks where the secure part ends. The secure part always starts at the region base and covers (watermark + 1) granules. The RAM region uses 1 KiB granules and an 8-bit watermark. The flash region uses 8 KiB granules and a 7-bit watermark. Whatever lies above the boundary, up to the last byte of the region, is non-secure.

Addresses enter on a valid/ready stream together with the watermark values from the configuration bank. The watermarks are sampled in the same cycle as the address, so a new watermark applies to the next access that is accepted. The verdict leaves one cycle later on a second valid/ready stream. It carries one in-region flag per region and a secure flag. An address in neither region raises no region flag and reports non-secure. The output stage holds a single verdict. If the consumer keeps `out_ready` low while a verdict is pending, the verdict stays frozen and `in_ready` drops, so back-pressure reaches the producer without loss. A pending verdict and a new address can move in the same cycle.

The block only classifies. Blocking the access and the bus protocol belong to other logic. The two regions must not overlap.

Top module: `wm_secure_classifier`

## Requirements
- R1: An accepted address with RAM_BASE <= addr < RAM_BASE + (ram_wm+1)*1024 is reported with out_in_ram=1, out_in_flash=0 and out_secure=1.
- R2: An accepted address in the RAM region at or above RAM_BASE + (ram_wm+1)*1024, up to RAM_BASE + RAM_BYTES - 1, is reported with out_in_ram=1 and out_secure=0.
- R3: In the flash region the boundary is FLASH_BASE + (flash_wm+1)*8192. Addresses below it are reported with out_in_flash=1 and out_secure=1. Addresses from it to the last flash byte are reported with out_in_flash=1 and out_secure=0.
- R4: An accepted address in neither region is reported with out_in_ram=0, out_in_flash=0 and out_secure=0. out_secure=1 never appears without a region flag.
- R5: At the maximum watermark values (0xFF for RAM, 0x7F for flash) the boundary arithmetic does not overflow. The whole 256 KiB RAM region and the whole 1 MiB flash region are secure, and the first byte past each region is reported as outside.
- R6: A verdict appears with out_valid=1 in the cycle after its address is accepted (in_valid=1 and in_ready=1 at a rising edge).
- R7: While out_valid=1 and out_ready=0, in_ready is 0 and every output flag keeps its value.
- R8: The watermarks are sampled when the address is accepted. A change made while the verdict is pending does not alter it, and the next accepted address uses the new value.
- R9: After reset, out_valid=0 and in_ready=1.
- R10: At most one of out_in_ram and out_in_flash is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Address stream valid |
| in_ready | output | 1 | Address stream ready |
| in_addr | input | ADDR_W | Access address |
| ram_wm | input | RAM_WM_W | RAM watermark, in 1 KiB granules minus one |
| flash_wm | input | FLASH_WM_W | Flash watermark, in 8 KiB granules minus one |
| out_valid | output | 1 | Verdict stream valid |
| out_ready | input | 1 | Verdict stream ready |
| out_in_ram | output | 1 | Address lies in the RAM region |
| out_in_flash | output | 1 | Address lies in the flash region |
| out_secure | output | 1 | Address lies in a secure part |

## Verification
Every value of each watermark is tried, all 256 for RAM and all 128 for flash. For each value the bench classifies the region base, the last secure byte, the first byte above the boundary and the last region byte. These probes separate an off-by-one in the boundary and a wrong granule shift. At the maximum value they also catch an overflowing sum. Addresses just below, between and just above the regions confirm the outside verdict. A stalled consumer is used to show frozen outputs, a blocked input and the moment the watermark is sampled.

// File: rtl/wm_cls_pkg.sv
package wm_cls_pkg;
  typedef struct packed {
    logic in_ram;
    logic in_flash;
    logic secure;
  } wm_verdict_t;
endpackage

// File: rtl/wm_region_match.sv
module wm_region_match #(
  parameter int                ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] BASE       = '0,
  parameter logic [ADDR_W:0]   SIZE       = 1,
  parameter int                GRAN_SHIFT = 10,
  parameter int                WM_W       = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [WM_W-1:0]   wm,
  output logic              in_region,
  output logic              secure
);
  // Two spare bits keep (wm+1) << shift and base+size free of overflow.
  localparam int EW = ADDR_W + 2;

  logic [EW-1:0] addr_x, offset, limit;

  always_comb begin
    addr_x    = EW'(addr);
    offset    = addr_x - EW'(BASE);
    limit     = (EW'(wm) + EW'(1)) << GRAN_SHIFT;
    in_region = (addr_x >= EW'(BASE)) && (offset < EW'(SIZE));
    secure    = in_region && (offset < limit);
  end
endmodule

// File: rtl/wm_out_stage.sv
module wm_out_stage
  import wm_cls_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  wm_verdict_t in_verdict,
  output logic        out_valid,
  input  logic        out_ready,
  output wm_verdict_t out_verdict
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_verdict <= '0;
    end else if (in_valid && in_ready) begin
      out_valid   <= 1'b1;
      out_verdict <= in_verdict;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end
endmodule

// File: rtl/wm_secure_classifier.sv
module wm_secure_classifier
  import wm_cls_pkg::*;
#(
  parameter int                ADDR_W           = 32,
  parameter logic [ADDR_W-1:0] RAM_BASE         = 32'h2000_0000,
  parameter logic [ADDR_W:0]   RAM_BYTES        = 33'h0_0004_0000,
  parameter logic [ADDR_W-1:0] FLASH_BASE       = 32'h0800_0000,
  parameter logic [ADDR_W:0]   FLASH_BYTES      = 33'h0_0010_0000,
  parameter int                RAM_WM_W         = 8,
  parameter int                FLASH_WM_W       = 7,
  parameter int                RAM_GRAN_SHIFT   = 10,
  parameter int                FLASH_GRAN_SHIFT = 13
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [ADDR_W-1:0]     in_addr,
  input  logic [RAM_WM_W-1:0]   ram_wm,
  input  logic [FLASH_WM_W-1:0] flash_wm,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic                  out_in_ram,
  output logic                  out_in_flash,
  output logic                  out_secure
);
  logic        ram_hit, ram_sec, flash_hit, flash_sec;
  wm_verdict_t verdict_d, verdict_q;

  wm_region_match #(
    .ADDR_W(ADDR_W), .BASE(RAM_BASE), .SIZE(RAM_BYTES),
    .GRAN_SHIFT(RAM_GRAN_SHIFT), .WM_W(RAM_WM_W)
  ) u_ram_match (
    .addr(in_addr), .wm(ram_wm), .in_region(ram_hit), .secure(ram_sec)
  );

  wm_region_match #(
    .ADDR_W(ADDR_W), .BASE(FLASH_BASE), .SIZE(FLASH_BYTES),
    .GRAN_SHIFT(FLASH_GRAN_SHIFT), .WM_W(FLASH_WM_W)
  ) u_flash_match (
    .addr(in_addr), .wm(flash_wm), .in_region(flash_hit), .secure(flash_sec)
  );

  always_comb begin
    verdict_d.in_ram   = ram_hit;
    verdict_d.in_flash = flash_hit;
    verdict_d.secure   = ram_sec || flash_sec;
  end

  wm_out_stage u_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_verdict(verdict_d),
    .out_valid(out_valid), .out_ready(out_ready), .out_verdict(verdict_q)
  );

  assign out_in_ram   = verdict_q.in_ram;
  assign out_in_flash = verdict_q.in_flash;
  assign out_secure   = verdict_q.secure;
endmodule

// File: rtl/wm_classifier_chk.sv
module wm_classifier_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic out_valid,
  input logic out_ready,
  input logic out_in_ram,
  input logic out_in_flash,
  input logic out_secure
);
  AST_ONE_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_in_ram, out_in_flash})); // R10

  AST_SECURE_NEEDS_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    out_secure |-> (out_in_ram || out_in_flash)); // R4

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R6

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R7

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_in_ram) && $stable(out_in_flash) && $stable(out_secure))); // R7
endmodule

bind wm_secure_classifier wm_classifier_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_in_ram(out_in_ram),
  .out_in_flash(out_in_flash), .out_secure(out_secure)
);

// File: tb/wm_secure_classifier_bench.sv
module wm_secure_classifier_bench;
  localparam longint RB = 64'h2000_0000;
  localparam longint RS = 64'h0004_0000;
  localparam longint FB = 64'h0800_0000;
  localparam longint FS = 64'h0010_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_addr = '0;
  logic [7:0]  ram_wm = 8'hFF;
  logic [6:0]  flash_wm = 7'h7F;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_in_ram, out_in_flash, out_secure;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  wm_secure_classifier u_wm_secure_classifier (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .ram_wm(ram_wm), .flash_wm(flash_wm),
    .out_valid(out_valid), .out_ready(out_ready), .out_in_ram(out_in_ram),
    .out_in_flash(out_in_flash), .out_secure(out_secure)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got {valid,ram,flash,sec}=%b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [2:0] model(input longint a, input int rw, input int fw);
    logic ir, iff_, sec;
    ir   = (a >= RB) && (a < RB + RS);
    iff_ = (a >= FB) && (a < FB + FS);
    sec  = (ir && (a < RB + (rw + 1) * 1024)) || (iff_ && (a < FB + (fw + 1) * 8192));
    return {ir, iff_, sec};
  endfunction

  task automatic classify(input string req, input longint a, input int rw, input int fw);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a[31:0]; ram_wm = rw[7:0]; flash_wm = fw[6:0];
    @(negedge clk);
    in_valid = 1'b0;
    check(req, {out_valid, out_in_ram, out_in_flash, out_secure}, {1'b1, model(a, rw, fw)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: idle after reset
    check("R9", {out_valid, in_ready, 2'b00}, 4'b0100);

    // R1 R2 R5: every RAM watermark, probes at base, boundary and last byte
    for (int w = 0; w < 256; w++) begin
      longint lim = RB + (w + 1) * 1024;
      classify("R1", RB, w, 5);
      classify("R1", lim - 1, w, 5);
      classify((w == 255) ? "R5" : "R2", lim, w, 5);
      classify("R2", RB + RS - 1, w, 5);
    end
    // R3 R5: every flash watermark
    for (int w = 0; w < 128; w++) begin
      longint lim = FB + (w + 1) * 8192;
      classify("R3", FB, 9, w);
      classify("R3", lim - 1, 9, w);
      classify((w == 127) ? "R5" : "R3", lim, 9, w);
      classify("R3", FB + FS - 1, 9, w);
    end
    // R4: outside both regions
    classify("R4", RB - 1, 255, 127);
    classify("R4", FB - 1, 255, 127);
    classify("R4", FB + FS, 255, 127);
    classify("R4", RB + RS, 255, 127);
    classify("R4", 64'hFFFF_FFFF, 255, 127);
    classify("R4", 64'h0, 0, 0);

    // R6 R7 R8: stall with a watermark change while pending
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_addr = 32'h2000_0400; ram_wm = 8'h00;
    @(negedge clk);
    in_valid = 1'b0;
    check("R6", {out_valid, out_in_ram, out_in_flash, out_secure}, 4'b1100);
    ram_wm = 8'hFF;
    in_valid = 1'b1; in_addr = 32'h0800_0000;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R7", {out_valid, out_in_ram, out_in_flash, out_secure}, 4'b1100);
      check("R7", {3'b000, in_ready}, 4'b0000);
    end
    in_valid = 1'b0;
    check("R8", {out_valid, out_in_ram, out_in_flash, out_secure}, 4'b1100);
    out_ready = 1'b1;
    classify("R8", 64'h2000_0400, 255, 127);
    @(negedge clk);
    check("R6", {out_valid, 3'b000}, 4'b0000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule